// File: doc/BRIEF.md
# PHY Management Register Model

This block stands in for the management register file of one Ethernet PHY. Software reaches it through a single 32-bit management frame word on a memory-mapped bus. Writing that word starts one management access: the word is decoded into a direction, a PHY address, a register number and 16 data bits. A read leaves the chosen PHY register in the low half of the frame word. A write sends the data bits to the chosen register, and each register applies its own write mask and forced bits.

The model keeps the control, status, advertisement, interrupt-source and interrupt-mask registers. Two further registers read as fixed values. Auto-negotiation finishes at once, so setting the negotiation-enable bit in control marks negotiation complete in status straight away. A link-state input is watched for changes. Each change updates the link and negotiation bits in status and records an event in the interrupt-source register. Every access raises a sticky "management done" flag, which the host clears with a strobe.

Top module: `phy_mgmt_model`

## Requirements
- R1: After reset, control is 0x3000, status is 0x7809, advertisement is 0x01E1, interrupt source and interrupt mask are 0, the frame word is 0 and the done flag is 0.
- R2: Field layout of the frame word: bit 29 set means read and clear means write; bits 27:23 hold the PHY address; bits 22:18 hold the register number; bits 15:0 hold the data. Bits 31, 30, 28, 17 and 16 take no part in decoding.
- R3: One cycle after a frame write, the frame word holds the written word. For a read, bits 15:0 are replaced by the addressed register value and bits 31:16 keep the written value.
- R4: Every frame write, read or write, sets done_flag on the next cycle. done_clr clears the flag. If a frame write and done_clr fall in the same cycle, the set wins.
- R5: A control write stores the data AND 0x7980. If data bit 12 (negotiation enable) is set, status bit 5 (negotiation complete) is set in the same cycle.
- R6: An advertisement write stores (data AND 0x2D7F) OR 0x0080.
- R7: An interrupt-mask write keeps data bits 7:0. The upper bits read back as zero.
- R8: At the first clock edge after link_up rises, status bits 5 and 2 are set, and interrupt-source bits 7 and 6 are set. At the first clock edge after link_up falls, status bits 5 and 2 are cleared, and interrupt-source bit 4 is set.
- R9: Register numbers: 0 control, 1 status, 4 advertisement, 5 partner ability (reads 0x45E1), 6 expansion (reads 0x0001), 29 interrupt source, 30 interrupt mask. Every other number reads 0. Writes to any register other than 0, 4 and 30 change nothing.
- R10: A read of the interrupt source returns its value and clears it. A link event in the same cycle survives the clear.
- R11: Only PHY address PHY_ADDR (default 0) responds. At any other address, a read returns 0 in bits 15:0 and a write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_we | input | 1 | Write strobe for the management frame word |
| frame_wdata | input | 32 | Management frame word being written |
| done_clr | input | 1 | Clears the management-done flag |
| link_up | input | 1 | Current link state, 1 = up |
| frame_rdata | output | 32 | Current management frame word |
| done_flag | output | 1 | Sticky management-done flag |

## Verification
The bench builds the block with its default parameters: responding PHY address 0 and 5-bit PHY and register fields. This puts in reach foreign addresses such as 1, 3 and 31, as well as unmapped register numbers such as 2 and 31. The link input is driven through both edges. One edge is timed to land in the same cycle as an interrupt-source read, which exercises the ordering of clear-on-read against new events. Frame words carrying stray bits in the undecoded positions show that those bits are kept in the result and ignored in decoding.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int FRAME_W  = 32;
    localparam int DATA_W   = 16;
    localparam int KEEP_W   = FRAME_W - DATA_W;
    localparam int ADDR_W   = 5;
    localparam int OP_BIT   = 29;
    localparam int REG_LSB  = 18;
    localparam int PHY_LSB  = REG_LSB + ADDR_W;

    localparam logic [ADDR_W-1:0] RN_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] RN_STAT = 5'd1;
    localparam logic [ADDR_W-1:0] RN_ADV  = 5'd4;
    localparam logic [ADDR_W-1:0] RN_LPA  = 5'd5;
    localparam logic [ADDR_W-1:0] RN_EXP  = 5'd6;
    localparam logic [ADDR_W-1:0] RN_ISRC = 5'd29;
    localparam logic [ADDR_W-1:0] RN_IMSK = 5'd30;

    localparam logic [DATA_W-1:0] CTRL_INIT  = 16'h3000;
    localparam logic [DATA_W-1:0] STAT_INIT  = 16'h7809;
    localparam logic [DATA_W-1:0] ADV_INIT   = 16'h01E1;
    localparam logic [DATA_W-1:0] LPA_VALUE  = 16'h45E1;
    localparam logic [DATA_W-1:0] EXP_VALUE  = 16'h0001;

    localparam logic [DATA_W-1:0] CTRL_KEEP  = 16'h7980;
    localparam logic [DATA_W-1:0] ADV_KEEP   = 16'h2D7F;
    localparam logic [DATA_W-1:0] ADV_FORCE  = 16'h0080;
    localparam logic [DATA_W-1:0] IMSK_KEEP  = 16'h00FF;
    localparam int                ANEG_EN_BIT = 12;

    localparam logic [DATA_W-1:0] STAT_NEG_DONE = 16'h0020;
    localparam logic [DATA_W-1:0] STAT_LINK_SET = 16'h0024;
    localparam logic [DATA_W-1:0] ISRC_UP_EVT   = 16'h00C0;
    localparam logic [DATA_W-1:0] ISRC_DN_EVT   = 16'h0010;

    typedef struct packed {
        logic [KEEP_W-1:0] keep;
        logic              rd;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] reg_a;
        logic [DATA_W-1:0] data;
    } mgmt_cmd_t;

    typedef enum logic [2:0] {
        SEL_CTRL, SEL_STAT, SEL_ADV, SEL_LPA,
        SEL_EXP, SEL_ISRC, SEL_IMSK, SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] rn);
        reg_sel_e s;
        case (rn)
            RN_CTRL: s = SEL_CTRL;
            RN_STAT: s = SEL_STAT;
            RN_ADV:  s = SEL_ADV;
            RN_LPA:  s = SEL_LPA;
            RN_EXP:  s = SEL_EXP;
            RN_ISRC: s = SEL_ISRC;
            RN_IMSK: s = SEL_IMSK;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] adv_apply(input logic [DATA_W-1:0] v);
        return (v & ADV_KEEP) | ADV_FORCE;
    endfunction

endpackage

// File: rtl/mgmt_frame_decode.sv
module mgmt_frame_decode
    import phy_mgmt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PHY_ADDR = '0
) (
    input  logic [FRAME_W-1:0] frame,
    output mgmt_cmd_t          cmd,
    output logic               hit
);
    always_comb begin
        cmd.keep  = frame[FRAME_W-1:DATA_W];
        cmd.rd    = frame[OP_BIT];
        cmd.phy   = frame[PHY_LSB +: ADDR_W];
        cmd.reg_a = frame[REG_LSB +: ADDR_W];
        cmd.data  = frame[DATA_W-1:0];
        hit       = (cmd.phy == PHY_ADDR);
    end
endmodule

// File: rtl/phy_link_tracker.sv
module phy_link_tracker (
    input  logic clk,
    input  logic rst,
    input  logic link_up,
    output logic link_rise,
    output logic link_fall
);
    logic link_q;

    always_ff @(posedge clk) begin
        if (rst) link_q <= 1'b0;
        else     link_q <= link_up;
    end

    assign link_rise = link_up & ~link_q;
    assign link_fall = ~link_up & link_q;
endmodule

// File: rtl/phy_regfile.sv
module phy_regfile
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  mgmt_cmd_t         cmd,
    input  logic              hit,
    input  logic              link_rise,
    input  logic              link_fall,
    output logic [DATA_W-1:0] rd_val
);
    logic [DATA_W-1:0] ctrl_q, stat_q, adv_q, isrc_q, imsk_q;
    logic [DATA_W-1:0] stat_n, isrc_n;
    reg_sel_e          sel;
    logic              wr, rdacc;

    assign sel   = decode_sel(cmd.reg_a);
    assign wr    = acc & hit & ~cmd.rd;
    assign rdacc = acc & hit & cmd.rd;

    always_comb begin
        rd_val = '0;
        if (hit) begin
            case (sel)
                SEL_CTRL: rd_val = ctrl_q;
                SEL_STAT: rd_val = stat_q;
                SEL_ADV:  rd_val = adv_q;
                SEL_LPA:  rd_val = LPA_VALUE;
                SEL_EXP:  rd_val = EXP_VALUE;
                SEL_ISRC: rd_val = isrc_q;
                SEL_IMSK: rd_val = imsk_q;
                default:  rd_val = '0;
            endcase
        end
    end

    always_comb begin
        stat_n = stat_q;
        if (wr && sel == SEL_CTRL && cmd.data[ANEG_EN_BIT])
            stat_n = stat_n | STAT_NEG_DONE;
        if (link_rise) stat_n = stat_n | STAT_LINK_SET;
        if (link_fall) stat_n = stat_n & ~STAT_LINK_SET;

        isrc_n = (rdacc && sel == SEL_ISRC) ? '0 : isrc_q;
        if (link_rise) isrc_n = isrc_n | ISRC_UP_EVT;
        if (link_fall) isrc_n = isrc_n | ISRC_DN_EVT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_INIT;
            stat_q <= STAT_INIT;
            adv_q  <= ADV_INIT;
            isrc_q <= '0;
            imsk_q <= '0;
        end else begin
            stat_q <= stat_n;
            isrc_q <= isrc_n;
            if (wr && sel == SEL_CTRL) ctrl_q <= cmd.data & CTRL_KEEP;
            if (wr && sel == SEL_ADV)  adv_q  <= adv_apply(cmd.data);
            if (wr && sel == SEL_IMSK) imsk_q <= cmd.data & IMSK_KEEP;
        end
    end

    // R5
    ctrl_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_CTRL) |=> (ctrl_q == ($past(cmd.data) & CTRL_KEEP)));

    // R5
    aneg_done_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_CTRL && cmd.data[ANEG_EN_BIT] && !link_fall) |=> stat_q[5]);

    // R6
    adv_force_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_ADV) |=> (adv_q == (($past(cmd.data) & ADV_KEEP) | ADV_FORCE)));

    // R7
    imsk_low_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_IMSK) |=> (imsk_q == {8'h00, $past(cmd.data[7:0])}));

    // R8
    link_up_chk: assert property (@(posedge clk) disable iff (rst)
        link_rise |=> (stat_q[5] && stat_q[2] && isrc_q[7] && isrc_q[6]));

    // R8
    link_down_chk: assert property (@(posedge clk) disable iff (rst)
        link_fall |=> (!stat_q[5] && !stat_q[2] && isrc_q[4]));

    // R10
    isrc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rdacc && sel == SEL_ISRC && !link_rise && !link_fall) |=> (isrc_q == '0));

    // R11
    foreign_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !hit) |=> ($stable(ctrl_q) && $stable(adv_q) && $stable(imsk_q)));
endmodule

// File: rtl/phy_mgmt_model.sv
module phy_mgmt_model
    import phy_mgmt_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PHY_ADDR = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_we,
    input  logic [FRAME_W-1:0] frame_wdata,
    input  logic               done_clr,
    input  logic               link_up,
    output logic [FRAME_W-1:0] frame_rdata,
    output logic               done_flag
);
    mgmt_cmd_t         cmd;
    logic              hit;
    logic              link_rise, link_fall;
    logic [DATA_W-1:0] rd_val;
    logic [FRAME_W-1:0] frame_q;
    logic              done_q;

    mgmt_frame_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
        .frame (frame_wdata),
        .cmd   (cmd),
        .hit   (hit)
    );

    phy_link_tracker u_link (
        .clk       (clk),
        .rst       (rst),
        .link_up   (link_up),
        .link_rise (link_rise),
        .link_fall (link_fall)
    );

    phy_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .acc       (frame_we),
        .cmd       (cmd),
        .hit       (hit),
        .link_rise (link_rise),
        .link_fall (link_fall),
        .rd_val    (rd_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (frame_we)
                frame_q <= cmd.rd ? {cmd.keep, rd_val} : frame_wdata;
            if (frame_we)      done_q <= 1'b1;
            else if (done_clr) done_q <= 1'b0;
        end
    end

    assign frame_rdata = frame_q;
    assign done_flag   = done_q;

    // R4
    done_set_chk: assert property (@(posedge clk) disable iff (rst)
        frame_we |=> done_flag);

    // R3
    read_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_we && frame_wdata[OP_BIT]) |=>
        (frame_rdata[FRAME_W-1:DATA_W] == $past(frame_wdata[FRAME_W-1:DATA_W])));
endmodule

// File: tb/phy_mgmt_model_test.sv
`timescale 1ns/1ps
module phy_mgmt_model_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_we = 1'b0;
    logic [31:0] frame_wdata = '0;
    logic        done_clr = 1'b0;
    logic        link_up = 1'b0;
    logic [31:0] frame_rdata;
    logic        done_flag;

    int total = 0;
    int bad   = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    phy_mgmt_model uut (
        .clk(clk), .rst(rst), .frame_we(frame_we), .frame_wdata(frame_wdata),
        .done_clr(done_clr), .link_up(link_up),
        .frame_rdata(frame_rdata), .done_flag(done_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Driver: called just after a falling edge; pushes the expected frame word.
    task automatic access(input logic rd, input logic [4:0] phy, input logic [4:0] rn,
                          input logic [15:0] data, input logic [15:0] rv,
                          input string tag, input logic [31:0] extra = 32'h0);
        logic [31:0] f;
        f = extra | {2'b00, rd, 1'b0, phy, rn, 2'b00, data};
        exp_q.push_back(rd ? {f[31:16], rv} : f);
        tag_q.push_back(tag);
        frame_we    = 1'b1;
        frame_wdata = f;
        @(negedge clk);
        frame_we    = 1'b0;
    endtask

    // Monitor: after each accepted write, compare at the next falling edge.
    initial begin
        forever begin
            @(posedge clk);
            if (frame_we === 1'b1 && rst === 1'b0) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    chk("scoreboard underflow", frame_rdata, 32'hFFFF_FFFF);
                end else begin
                    automatic logic [31:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    chk(t, frame_rdata, e);
                    chk({"R4 done after ", t}, {31'b0, done_flag}, 32'h1);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 frame reset", frame_rdata, 32'h0);
        chk("R1 done reset", {31'b0, done_flag}, 32'h0);

        access(1, 0, 0,  16'h0, 16'h3000, "R1 control reset");
        access(1, 0, 1,  16'h0, 16'h7809, "R1 status reset");
        access(1, 0, 4,  16'h0, 16'h01E1, "R1 advert reset");
        access(1, 0, 29, 16'h0, 16'h0000, "R1 isrc reset");
        access(1, 0, 30, 16'h0, 16'h0000, "R1 imask reset");

        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        chk("R4 done cleared", {31'b0, done_flag}, 32'h0);
        done_clr = 1'b1;
        access(1, 0, 0, 16'h0, 16'h3000, "R4 set beats clear");
        done_clr = 1'b0;

        // R5 control mask, negotiation bit clear then set
        access(0, 0, 0, 16'h8E7F, 16'h0, "R3 write frame kept");
        access(1, 0, 0, 16'h0, 16'h0800, "R5 control mask");
        access(1, 0, 1, 16'h0, 16'h7809, "R5 status no aneg");
        access(0, 0, 0, 16'hFFFF, 16'h0, "R5 control write");
        access(1, 0, 0, 16'h0, 16'h7980, "R5 control full mask");
        access(1, 0, 1, 16'h0, 16'h7829, "R5 aneg complete");

        // R6 advertisement
        access(0, 0, 4, 16'h0000, 16'h0, "R6 adv write zero");
        access(1, 0, 4, 16'h0, 16'h0080, "R6 adv forced bit");
        access(0, 0, 4, 16'hFFFF, 16'h0, "R6 adv write ones");
        access(1, 0, 4, 16'h0, 16'h2DFF, "R6 adv mask");

        // R7 interrupt mask
        access(0, 0, 30, 16'hABCD, 16'h0, "R7 imask write");
        access(1, 0, 30, 16'h0, 16'h00CD, "R7 imask low byte");

        // R9 map and ignored writes
        access(0, 0, 1,  16'h0000, 16'h0, "R9 status write");
        access(1, 0, 1,  16'h0, 16'h7829, "R9 status unchanged");
        access(1, 0, 5,  16'h0, 16'h45E1, "R9 partner ability");
        access(1, 0, 6,  16'h0, 16'h0001, "R9 expansion");
        access(1, 0, 2,  16'h0, 16'h0000, "R9 unmapped 2");
        access(1, 0, 31, 16'h0, 16'h0000, "R9 unmapped 31");
        access(0, 0, 29, 16'hFFFF, 16'h0, "R9 isrc write");
        access(1, 0, 29, 16'h0, 16'h0000, "R9 isrc unchanged");

        // R8 link up then down
        link_up = 1'b1;
        @(negedge clk);
        @(negedge clk);
        access(1, 0, 1,  16'h0, 16'h782D, "R8 link up status");
        access(1, 0, 29, 16'h0, 16'h00C0, "R8 link up events");
        access(1, 0, 29, 16'h0, 16'h0000, "R10 isrc cleared");
        link_up = 1'b0;
        @(negedge clk);
        @(negedge clk);
        access(1, 0, 1,  16'h0, 16'h7809, "R8 link down status");
        access(1, 0, 29, 16'h0, 16'h0010, "R8 link down event");

        // R10 event in the same cycle as a clearing read
        link_up = 1'b1;
        access(1, 0, 29, 16'h0, 16'h0000, "R10 read during event");
        access(1, 0, 29, 16'h0, 16'h00C0, "R10 event kept");

        // R11 foreign PHY addresses
        access(0, 1,  0, 16'h1000, 16'h0, "R11 foreign write");
        access(0, 31, 4, 16'h0000, 16'h0, "R11 foreign adv write");
        access(1, 3,  1, 16'h0, 16'h0000, "R11 foreign read");
        access(1, 0,  0, 16'h0, 16'h7980, "R11 control intact");
        access(1, 0,  4, 16'h0, 16'h2DFF, "R11 adv intact");

        // R2 undecoded bits kept and ignored
        access(1, 0, 4, 16'h0, 16'h2DFF, "R2 stray bits read", 32'hD003_0000);
        access(0, 0, 30, 16'h0012, 16'h0, "R2 stray bits write", 32'hD003_0000);
        access(1, 0, 30, 16'h0, 16'h0012, "R2 write decoded");

        repeat (2) @(negedge clk);
        chk("R3 scoreboard drained", exp_q.size(), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule